// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block decides when a real-time-clock alarm goes off. It receives the running calendar time as BCD fields: seconds, minutes, hours, day-of-week and date. It also receives a programmed alarm setting of seconds, minutes, hours and one shared day/date value. Four skip bits (seconds, minutes, hours, day) and a week/month select bit choose one of six repeat rates. A skip bit set on a finer unit overrides every coarser field.

The comparison is taken only in the clock cycle that carries the once-per-second tick. A qualifying match with the alarm enabled sets a sticky flag, and the flag stays set until a clear pulse. The timekeeping counters, the oscillator and any register access sit outside the block.

Top module: `cal_alarm_match`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `alarm_flag` is 0 after that edge.
- R2: With `skip_sec`=1, every enabled tick sets the flag, whatever the other skip bits and all field values are.
- R3: With `skip_sec`=0 and `skip_min`=1, an enabled tick sets the flag only when `now_sec` equals `set_sec`.
- R4: With `skip_sec`=`skip_min`=0 and `skip_hr`=1, seconds and minutes must both match.
- R5: With the three lower skip bits 0 and `skip_day`=1, seconds, minutes and hours must match, and day-of-week and date are ignored.
- R6: With all skip bits 0 and `week_sel`=1, seconds, minutes, hours and `now_dow`==`set_daydate` must match, and `now_date` is ignored.
- R7: With all skip bits 0 and `week_sel`=0, seconds, minutes, hours and `now_date`==`set_daydate` must match, and `now_dow` is ignored.
- R8: A match in a cycle with `sec_tick`=0 never sets the flag.
- R9: With `alarm_en`=0, no tick or match sets the flag.
- R10: Once set, the flag stays 1 until `flag_clr`=1 at a clock edge, which clears it. A clear in the same cycle as a qualifying tick leaves the flag 0.
- R11: The flag rises at the rising edge that samples the qualifying tick. It is still 0 in that tick cycle and is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| alarm_en | input | 1 | Alarm enable, 0 after power-up |
| flag_clr | input | 1 | Clear pulse for the flag |
| now_sec | input | FIELD_W | Current seconds, BCD |
| now_min | input | FIELD_W | Current minutes, BCD |
| now_hr | input | FIELD_W | Current hours, BCD |
| now_dow | input | FIELD_W | Current day of week |
| now_date | input | FIELD_W | Current date of month, BCD |
| set_sec | input | FIELD_W | Alarm seconds |
| set_min | input | FIELD_W | Alarm minutes |
| set_hr | input | FIELD_W | Alarm hours |
| set_daydate | input | FIELD_W | Alarm day-of-week or date, chosen by week_sel |
| skip_sec | input | 1 | Ignore all fields, fire every second |
| skip_min | input | 1 | Ignore minutes and coarser fields |
| skip_hr | input | 1 | Ignore hours and coarser fields |
| skip_day | input | 1 | Ignore day/date |
| week_sel | input | 1 | 1: day/date compares day-of-week, 0: date |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
A wrong decode of the skip bits shows up as a flag that rises on a tick where a needed field differs, or stays low where all needed fields agree. Either error is visible one cycle after that tick. A flag register that fails to hold, or that ignores the clear, diverges from the reference model on the next clock edge. The bench compares the flag to the model in every cycle, so any such error is reported within one cycle of the stimulus that exposes it.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

   localparam int NFIELD = 5;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HR   = 2;
   localparam int F_DOW  = 3;
   localparam int F_DATE = 4;

   typedef enum logic [2:0] {
      RATE_SEC,
      RATE_MIN,
      RATE_HOUR,
      RATE_DAY,
      RATE_WEEK,
      RATE_MONTH
   } rate_e;

   function automatic rate_e rate_of(input logic s, input logic m,
                                     input logic h, input logic d,
                                     input logic wk);
      if (s)       return RATE_SEC;
      else if (m)  return RATE_MIN;
      else if (h)  return RATE_HOUR;
      else if (d)  return RATE_DAY;
      else if (wk) return RATE_WEEK;
      else         return RATE_MONTH;
   endfunction

   function automatic logic [NFIELD-1:0] need_of(input rate_e r);
      logic [NFIELD-1:0] n;
      n = '0;
      case (r)
         RATE_SEC:   n = '0;
         RATE_MIN:   n[F_SEC] = 1'b1;
         RATE_HOUR:  begin n[F_SEC] = 1'b1; n[F_MIN] = 1'b1; end
         RATE_DAY:   begin n[F_SEC] = 1'b1; n[F_MIN] = 1'b1; n[F_HR] = 1'b1; end
         RATE_WEEK:  begin n[F_SEC] = 1'b1; n[F_MIN] = 1'b1; n[F_HR] = 1'b1;
                           n[F_DOW] = 1'b1; end
         RATE_MONTH: begin n[F_SEC] = 1'b1; n[F_MIN] = 1'b1; n[F_HR] = 1'b1;
                           n[F_DATE] = 1'b1; end
         default:    n = '0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/cal_alarm_rate_dec.sv
module cal_alarm_rate_dec
   import cal_alarm_pkg::*;
#(
   parameter bit SOP_FORM = 1'b0
) (
   input  logic              skip_sec,
   input  logic              skip_min,
   input  logic              skip_hr,
   input  logic              skip_day,
   input  logic              week_sel,
   output logic [NFIELD-1:0] need
);

   generate
      if (SOP_FORM) begin : g_sop
         logic thru_min, thru_hr, thru_day;
         assign thru_min     = ~skip_sec;
         assign thru_hr      = thru_min & ~skip_min;
         assign thru_day     = thru_hr & ~skip_hr;
         assign need[F_SEC]  = thru_min;
         assign need[F_MIN]  = thru_hr;
         assign need[F_HR]   = thru_day;
         assign need[F_DOW]  = thru_day & ~skip_day & week_sel;
         assign need[F_DATE] = thru_day & ~skip_day & ~week_sel;
      end else begin : g_enum
         rate_e rate;
         always_comb begin
            rate = rate_of(skip_sec, skip_min, skip_hr, skip_day, week_sel);
            need = need_of(rate);
         end
      end
   endgenerate

endmodule

// File: rtl/cal_alarm_field_cmp.sv
module cal_alarm_field_cmp #(
   parameter int FIELD_W = 8,
   parameter int NF      = 5,
   localparam int FLAT_W = NF * FIELD_W
) (
   input  logic [FLAT_W-1:0] now_v,
   input  logic [FLAT_W-1:0] ref_v,
   input  logic [NF-1:0]     need,
   output logic              hit
);

   logic [NF-1:0] ok;

   generate
      for (genvar i = 0; i < NF; i++) begin : g_fld
         assign ok[i] = ~need[i] |
                        (now_v[i*FIELD_W +: FIELD_W] == ref_v[i*FIELD_W +: FIELD_W]);
      end
   endgenerate

   assign hit = &ok;

endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   input  logic hit,
   input  logic clr,
   output logic flag
);

   logic fire;
   assign fire = tick & en & hit;

   always_ff @(posedge clk) begin
      if (!rst_n)     flag <= 1'b0;
      else if (clr)   flag <= 1'b0;
      else if (fire)  flag <= 1'b1;
   end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
   import cal_alarm_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter bit DEC_SOP = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_tick,
   input  logic               alarm_en,
   input  logic               flag_clr,
   input  logic [FIELD_W-1:0] now_sec,
   input  logic [FIELD_W-1:0] now_min,
   input  logic [FIELD_W-1:0] now_hr,
   input  logic [FIELD_W-1:0] now_dow,
   input  logic [FIELD_W-1:0] now_date,
   input  logic [FIELD_W-1:0] set_sec,
   input  logic [FIELD_W-1:0] set_min,
   input  logic [FIELD_W-1:0] set_hr,
   input  logic [FIELD_W-1:0] set_daydate,
   input  logic               skip_sec,
   input  logic               skip_min,
   input  logic               skip_hr,
   input  logic               skip_day,
   input  logic               week_sel,
   output logic               alarm_flag
);

   localparam int FLAT_W = NFIELD * FIELD_W;

   generate
      if (FIELD_W < 7 || FIELD_W > 8) begin : g_bad_width
         $error("cal_alarm_match: FIELD_W must be 7 or 8");
      end
   endgenerate

   logic [FLAT_W-1:0] now_flat, ref_flat;
   logic [NFIELD-1:0] need;
   logic              hit;

   assign now_flat[F_SEC*FIELD_W  +: FIELD_W] = now_sec;
   assign now_flat[F_MIN*FIELD_W  +: FIELD_W] = now_min;
   assign now_flat[F_HR*FIELD_W   +: FIELD_W] = now_hr;
   assign now_flat[F_DOW*FIELD_W  +: FIELD_W] = now_dow;
   assign now_flat[F_DATE*FIELD_W +: FIELD_W] = now_date;

   assign ref_flat[F_SEC*FIELD_W  +: FIELD_W] = set_sec;
   assign ref_flat[F_MIN*FIELD_W  +: FIELD_W] = set_min;
   assign ref_flat[F_HR*FIELD_W   +: FIELD_W] = set_hr;
   assign ref_flat[F_DOW*FIELD_W  +: FIELD_W] = set_daydate;
   assign ref_flat[F_DATE*FIELD_W +: FIELD_W] = set_daydate;

   cal_alarm_rate_dec #(.SOP_FORM(DEC_SOP)) u_dec (
      .skip_sec (skip_sec),
      .skip_min (skip_min),
      .skip_hr  (skip_hr),
      .skip_day (skip_day),
      .week_sel (week_sel),
      .need     (need)
   );

   cal_alarm_field_cmp #(.FIELD_W(FIELD_W), .NF(NFIELD)) u_cmp (
      .now_v (now_flat),
      .ref_v (ref_flat),
      .need  (need),
      .hit   (hit)
   );

   cal_alarm_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (sec_tick),
      .en    (alarm_en),
      .hit   (hit),
      .clr   (flag_clr),
      .flag  (alarm_flag)
   );

endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk #(
   parameter int FIELD_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sec_tick,
   input logic               alarm_en,
   input logic               flag_clr,
   input logic [FIELD_W-1:0] now_sec,
   input logic [FIELD_W-1:0] set_sec,
   input logic               skip_sec,
   input logic               skip_min,
   input logic               alarm_flag
);

   // R8 and R9: a rising flag needs an enabled tick in the previous cycle
   p_rise_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(sec_tick && alarm_en));

   p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_en && !alarm_flag) |=> !alarm_flag);

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !flag_clr) |=> alarm_flag);

   p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> !alarm_flag);

   p_every_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && alarm_en && skip_sec && !flag_clr) |=> alarm_flag);

   p_minute_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && alarm_en && !skip_sec && skip_min && !flag_clr &&
       now_sec == set_sec) |=> alarm_flag);

endmodule

bind cal_alarm_match cal_alarm_match_chk #(.FIELD_W(FIELD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sec_tick   (sec_tick),
   .alarm_en   (alarm_en),
   .flag_clr   (flag_clr),
   .now_sec    (now_sec),
   .set_sec    (set_sec),
   .skip_sec   (skip_sec),
   .skip_min   (skip_min),
   .alarm_flag (alarm_flag)
);

// File: tb/sim_cal_alarm_match.sv
`timescale 1ns/1ps
module sim_cal_alarm_match;

   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_tick = 1'b0, alarm_en = 1'b0, flag_clr = 1'b0;
   logic [W-1:0] now_sec = '0, now_min = '0, now_hr = '0, now_dow = '0, now_date = '0;
   logic [W-1:0] set_sec = '0, set_min = '0, set_hr = '0, set_daydate = '0;
   logic skip_sec = 1'b0, skip_min = 1'b0, skip_hr = 1'b0, skip_day = 1'b0, week_sel = 1'b0;
   logic alarm_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic model = 1'b0;

   always #2.5 clk = ~clk;

   cal_alarm_match #(.FIELD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .alarm_en(alarm_en),
      .flag_clr(flag_clr), .now_sec(now_sec), .now_min(now_min), .now_hr(now_hr),
      .now_dow(now_dow), .now_date(now_date), .set_sec(set_sec), .set_min(set_min),
      .set_hr(set_hr), .set_daydate(set_daydate), .skip_sec(skip_sec),
      .skip_min(skip_min), .skip_hr(skip_hr), .skip_day(skip_day),
      .week_sel(week_sel), .alarm_flag(alarm_flag)
   );

   // Rule-based reading of the repeat rates
   function automatic bit ref_match();
      bit s_ok = (now_sec == set_sec);
      bit m_ok = (now_min == set_min);
      bit h_ok = (now_hr == set_hr);
      if (skip_sec) return 1'b1;
      if (skip_min) return s_ok;
      if (skip_hr)  return s_ok && m_ok;
      if (skip_day) return s_ok && m_ok && h_ok;
      if (week_sel) return s_ok && m_ok && h_ok && (now_dow == set_daydate);
      return s_ok && m_ok && h_ok && (now_date == set_daydate);
   endfunction

   always @(posedge clk) begin
      if (!rst_n)                                    model <= 1'b0;
      else if (flag_clr)                             model <= 1'b0;
      else if (sec_tick && alarm_en && ref_match())  model <= 1'b1;
   end

   // Per-cycle comparison against the model (R11 timing)
   always @(negedge clk) begin
      if (!done) begin
         n_chk++;
         if (alarm_flag !== model) begin
            n_fail++;
            $display("FAIL R11 per-cycle model at %0t: actual %b expected %b",
                     $time, alarm_flag, model);
         end
      end
   end

   task automatic chk(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, got, exp);
      end
   endtask

   task automatic tick_once();
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0; #1;
   endtask

   task automatic clear_flag();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0; #1;
   endtask

   task automatic set_skips(input bit s, input bit m, input bit h, input bit d, input bit wk);
      skip_sec = s; skip_min = m; skip_hr = h; skip_day = d; week_sel = wk;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 chk("R1 reset", alarm_flag, 1'b0);
      @(negedge clk); rst_n = 1'b1; #1;

      now_sec = 8'h30; now_min = 8'h41; now_hr = 8'h09; now_dow = 8'h04; now_date = 8'h18;
      set_sec = 8'h15; set_min = 8'h42; set_hr = 8'h07; set_daydate = 8'h03;

      // R9: disabled
      set_skips(1, 0, 0, 0, 0); alarm_en = 1'b0;
      tick_once(); chk("R9 disabled tick", alarm_flag, 1'b0);

      // R8: no tick
      alarm_en = 1'b1;
      repeat (4) @(negedge clk); #1;
      chk("R8 no tick", alarm_flag, 1'b0);

      // R2 and R11
      @(negedge clk); sec_tick = 1'b1; #1;
      chk("R11 still low in tick cycle", alarm_flag, 1'b0);
      @(negedge clk); sec_tick = 1'b0; #1;
      chk("R11 high after tick edge", alarm_flag, 1'b1);
      chk("R2 every second", alarm_flag, 1'b1);
      repeat (3) @(negedge clk); #1;
      chk("R10 sticky", alarm_flag, 1'b1);
      clear_flag(); chk("R10 cleared", alarm_flag, 1'b0);

      // R3 minute rate
      set_skips(0, 1, 0, 0, 0);
      now_sec = 8'h14; tick_once(); chk("R3 sec mismatch", alarm_flag, 1'b0);
      now_sec = 8'h15; tick_once(); chk("R3 sec match", alarm_flag, 1'b1);
      clear_flag();

      // R4 hour rate
      set_skips(0, 0, 1, 0, 0);
      now_min = 8'h41; tick_once(); chk("R4 min mismatch", alarm_flag, 1'b0);
      now_min = 8'h42; tick_once(); chk("R4 sec+min match", alarm_flag, 1'b1);
      clear_flag();

      // R5 day rate
      set_skips(0, 0, 0, 1, 0);
      tick_once(); chk("R5 hour mismatch", alarm_flag, 1'b0);
      now_hr = 8'h07; now_dow = 8'h06; now_date = 8'h29;
      tick_once(); chk("R5 day/date ignored", alarm_flag, 1'b1);
      clear_flag();

      // R6 week rate
      set_skips(0, 0, 0, 0, 1);
      now_dow = 8'h04; now_date = 8'h03;
      tick_once(); chk("R6 dow mismatch, date equal", alarm_flag, 1'b0);
      now_dow = 8'h03; now_date = 8'h17;
      tick_once(); chk("R6 dow match", alarm_flag, 1'b1);
      clear_flag();

      // R7 month rate
      set_skips(0, 0, 0, 0, 0); set_daydate = 8'h17;
      now_dow = 8'h17; now_date = 8'h18;
      tick_once(); chk("R7 date mismatch, dow equal", alarm_flag, 1'b0);
      now_dow = 8'h02; now_date = 8'h17;
      tick_once(); chk("R7 date match", alarm_flag, 1'b1);

      // R10 clear wins over coincident match
      @(negedge clk); sec_tick = 1'b1; flag_clr = 1'b1;
      @(negedge clk); sec_tick = 1'b0; flag_clr = 1'b0; #1;
      chk("R10 clear beats match", alarm_flag, 1'b0);

      // R1: reset in mid-run clears a set flag
      tick_once(); chk("R7 re-arm", alarm_flag, 1'b1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); #1 chk("R1 reset mid-run", alarm_flag, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule